// File: doc/BRIEF.md
# Subarray-Aware Refresh-Access Arbiter

This block guards the activate path of a single DRAM bank that is split into subarrays. Each subarray refreshes through its own row buffer, and the refresh address runs on a path separate from the access address. A refresh therefore occupies only one subarray. The block tracks that subarray and still admits row activates to every other subarray while the refresh runs. An activate aimed at the subarray under refresh is held back until the refresh ends.

A refresh command (`ref_req`) is accepted only when no refresh is running. It captures the subarray selected by an internal refresh group pointer and starts a busy timer of `TRFC` cycles. The pointer then advances by one refresh group of `REF_ROWS` rows and wraps at the end of the bank. Activates arrive on a valid/ready stream. The source presents `act_valid` with `act_row` and must hold both unchanged until it sees `act_ready`. An activate transfers in the cycle where both are high. `act_ready` never depends on `act_valid`. It can depend on `act_row` and `ref_req` in the same cycle. Two spacing limits apply between accepted activates: a minimum gap to the previous activate, and a four-activate window. Both limits take larger values in any cycle where a refresh is running, because the refresh adds to the power drawn at the same time.

Top module: `subarray_refresh_arbiter`

## Requirements
- R1: After reset `ref_busy` is 0 and `ref_sa` is 0. With no refresh and no earlier activate, `act_ready` is 1 for any row.
- R2: A `ref_req` seen while `ref_busy` is 0 starts a refresh. `ref_busy` is 1 from the next cycle for exactly `TRFC` cycles. During those cycles `ref_sa` holds the top `SA_W` bits of the refresh pointer as it stood at the start.
- R3: A `ref_req` seen while `ref_busy` is 1 is ignored. It does not lengthen the busy period and does not advance the refresh pointer.
- R4: Each accepted refresh advances the pointer by `REF_ROWS` rows, and the pointer wraps at `2**ROW_W`. With the defaults, refresh number k (counting from 0) targets subarray (k*8 >> 7) mod 8. The 129th refresh, number 128, targets subarray 0 again.
- R5: The subarray of a row is `act_row[ROW_W-1 -: SA_W]`. `act_ready` is 0 for a row in subarray `ref_sa` while `ref_busy` is 1. It is also 0 for a row in the subarray that a refresh is starting on in the same cycle.
- R6: While a refresh runs, activates to any other subarray are accepted as soon as the spacing limits allow.
- R7: An activate is not accepted earlier than `TRRD` cycles after the previous accepted one. The limit is `TRRD_EXT` cycles instead when `ref_busy` is 1 in the candidate cycle.
- R8: An activate is not accepted earlier than `TFAW` cycles after the activate accepted four transfers before it. The limit is `TFAW_EXT` cycles instead when `ref_busy` is 1 in the candidate cycle.
- R9: A stalled activate whose valid and row stay fixed is accepted in the first cycle its subarray and spacing allow. `act_ready` is 0 in the cycle after any transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | input | 1 | Refresh command for this bank; taken only while idle |
| ref_busy | output | 1 | A refresh is running |
| ref_sa | output | SA_W | Subarray under refresh |
| act_valid | input | 1 | Activate request present |
| act_row | input | ROW_W | Row address of the activate |
| act_ready | output | 1 | Activate may transfer in this cycle |

## Verification
The assertions assume that the source keeps `act_valid` and `act_row` steady while a request is stalled. They also assume that `ref_req` is a clean one-cycle level that either the idle bank takes or the busy bank ignores. The stimulus drives every input on the falling clock edge. It keeps the request row fixed through each stall and through each spacing run. Spacing runs use rows outside the refreshing subarray, so a change in `act_ready` during a run comes only from the two spacing limits. The bench model predicts `act_ready` cycle by cycle from grant times it records itself.

// File: rtl/sarb_pkg.sv
package sarb_pkg;
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sarb_refresh_tracker.sv
module sarb_refresh_tracker #(
  parameter int ROW_W    = 10,
  parameter int SA_W     = 3,
  parameter int REF_ROWS = 8,
  parameter int TRFC     = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_req,
  output logic            busy,
  output logic            start,
  output logic [SA_W-1:0] sa_q,
  output logic [SA_W-1:0] next_sa
);
  localparam int GRP_W = $clog2(REF_ROWS);
  localparam int PTR_W = ROW_W - GRP_W;
  localparam int CNT_W = $clog2(TRFC + 1);
  localparam logic [CNT_W-1:0] RFC_LOAD = CNT_W'(TRFC);

  logic [PTR_W-1:0] grp_ptr;
  logic [CNT_W-1:0] rfc_cnt;

  assign busy    = (rfc_cnt != '0);
  assign start   = ref_req && !busy;
  assign next_sa = grp_ptr[PTR_W-1 -: SA_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_ptr <= '0;
      rfc_cnt <= '0;
      sa_q    <= '0;
    end else if (start) begin
      rfc_cnt <= RFC_LOAD;
      sa_q    <= next_sa;
      grp_ptr <= grp_ptr + 1'b1;
    end else if (busy) begin
      rfc_cnt <= rfc_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sarb_act_spacing.sv
module sarb_act_spacing
  import sarb_pkg::*;
#(
  parameter int TRRD     = 2,
  parameter int TRRD_EXT = 4,
  parameter int TFAW     = 10,
  parameter int TFAW_EXT = 16,
  parameter int WIN      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic ext,
  output logic ok
);
  localparam int AGE_MAX = imax(imax(TRRD, TRRD_EXT), imax(TFAW, TFAW_EXT));
  localparam int AGE_W   = $clog2(AGE_MAX + 1);
  localparam logic [AGE_W-1:0] AMAX  = AGE_W'(AGE_MAX);
  localparam logic [AGE_W-1:0] RRD_N = AGE_W'(TRRD);
  localparam logic [AGE_W-1:0] RRD_X = AGE_W'(TRRD_EXT);
  localparam logic [AGE_W-1:0] FAW_N = AGE_W'(TFAW);
  localparam logic [AGE_W-1:0] FAW_X = AGE_W'(TFAW_EXT);

  logic [AGE_W-1:0] age [WIN];
  logic [WIN-1:0]   vld;
  logic [AGE_W-1:0] rrd_lim, faw_lim;

  function automatic logic [AGE_W-1:0] bump(input logic [AGE_W-1:0] a);
    return (a == AMAX) ? a : a + 1'b1;
  endfunction

  for (genvar i = 0; i < WIN; i++) begin : g_hist
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          age[0] <= '0;
          vld[0] <= 1'b0;
        end else if (fire) begin
          age[0] <= AGE_W'(1);
          vld[0] <= 1'b1;
        end else begin
          age[0] <= bump(age[0]);
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          age[i] <= '0;
          vld[i] <= 1'b0;
        end else if (fire) begin
          age[i] <= bump(age[i-1]);
          vld[i] <= vld[i-1];
        end else begin
          age[i] <= bump(age[i]);
        end
      end
    end
  end

  assign rrd_lim = ext ? RRD_X : RRD_N;
  assign faw_lim = ext ? FAW_X : FAW_N;
  assign ok = (!vld[0] || (age[0] >= rrd_lim)) &&
              (!vld[WIN-1] || (age[WIN-1] >= faw_lim));
endmodule

// File: rtl/subarray_refresh_arbiter.sv
module subarray_refresh_arbiter #(
  parameter int ROW_W    = 10,
  parameter int SA_W     = 3,
  parameter int REF_ROWS = 8,
  parameter int TRFC     = 20,
  parameter int TRRD     = 2,
  parameter int TRRD_EXT = 4,
  parameter int TFAW     = 10,
  parameter int TFAW_EXT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_req,
  output logic             ref_busy,
  output logic [SA_W-1:0]  ref_sa,
  input  logic             act_valid,
  input  logic [ROW_W-1:0] act_row,
  output logic             act_ready
);
  logic            busy, start, space_ok, conflict, fire;
  logic [SA_W-1:0] sa_q, next_sa, act_sa;

  sarb_refresh_tracker #(
    .ROW_W(ROW_W), .SA_W(SA_W), .REF_ROWS(REF_ROWS), .TRFC(TRFC)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req),
    .busy(busy), .start(start), .sa_q(sa_q), .next_sa(next_sa)
  );

  sarb_act_spacing #(
    .TRRD(TRRD), .TRRD_EXT(TRRD_EXT), .TFAW(TFAW), .TFAW_EXT(TFAW_EXT), .WIN(4)
  ) u_spc (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ext(busy), .ok(space_ok)
  );

  assign act_sa    = act_row[ROW_W-1 -: SA_W];
  assign conflict  = busy ? (act_sa == sa_q) : (start && (act_sa == next_sa));
  assign act_ready = !conflict && space_ok;
  assign fire      = act_valid && act_ready;
  assign ref_busy  = busy;
  assign ref_sa    = sa_q;
endmodule

// File: rtl/sarb_checker.sv
module sarb_checker #(
  parameter int ROW_W    = 10,
  parameter int SA_W     = 3,
  parameter int TRFC     = 20,
  parameter int TRRD     = 2,
  parameter int TRRD_EXT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_req,
  input logic             ref_busy,
  input logic [SA_W-1:0]  ref_sa,
  input logic             act_valid,
  input logic [ROW_W-1:0] act_row,
  input logic             act_ready
);
  localparam int GAP_MAX = (TRRD_EXT > TRRD) ? TRRD_EXT : TRRD;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int RUN_W   = $clog2(TRFC + 2);
  localparam logic [GAP_W-1:0] G_N  = GAP_W'(TRRD);
  localparam logic [GAP_W-1:0] G_X  = GAP_W'(TRRD_EXT);
  localparam logic [GAP_W-1:0] G_MX = GAP_W'(GAP_MAX);
  localparam logic [RUN_W-1:0] R_LEN = RUN_W'(TRFC);

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  logic [RUN_W-1:0] run_q;
  logic             xfer;

  assign xfer = act_valid && act_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      run_q  <= '0;
    end else begin
      if (xfer) begin
        gap_q  <= GAP_W'(1);
        seen_q <= 1'b1;
      end else if (gap_q != G_MX) begin
        gap_q <= gap_q + 1'b1;
      end
      run_q <= ref_busy ? run_q + 1'b1 : '0;
    end
  end

  AST_BLOCK_SAME_SA: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_busy && (act_row[ROW_W-1 -: SA_W] == ref_sa)) |-> !act_ready); // R5
  AST_SA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_busy && $past(ref_busy)) |-> $stable(ref_sa)); // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_busy) |=> ref_busy); // R2
  AST_BUSY_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> (run_q < R_LEN)); // R3
  AST_BUSY_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_busy) |-> (run_q == R_LEN)); // R2
  AST_RRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && seen_q) |-> (gap_q >= (ref_busy ? G_X : G_N))); // R7
endmodule

bind subarray_refresh_arbiter sarb_checker #(
  .ROW_W(ROW_W), .SA_W(SA_W), .TRFC(TRFC), .TRRD(TRRD), .TRRD_EXT(TRRD_EXT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_busy(ref_busy),
  .ref_sa(ref_sa), .act_valid(act_valid), .act_row(act_row), .act_ready(act_ready)
);

// File: tb/tb_subarray_refresh_arbiter.sv
`timescale 1ns/1ps
module tb_subarray_refresh_arbiter;
  localparam int ROW_W = 10, SA_W = 3, REF_ROWS = 8, TRFC = 20;
  localparam int TRRD = 2, TRRD_EXT = 4, TFAW = 10, TFAW_EXT = 16;

  // {row, expected ready} while subarray 0 refreshes and no activate is pending
  localparam logic [10:0] VEC [8] = '{
    {10'h000, 1'b0}, {10'h07F, 1'b0}, {10'h080, 1'b1}, {10'h1A5, 1'b1},
    {10'h3FF, 1'b1}, {10'h27C, 1'b1}, {10'h055, 1'b0}, {10'h300, 1'b1}
  };

  logic clk = 0, rst_n = 0, ref_req = 0, act_valid = 0;
  logic [ROW_W-1:0] act_row = '0;
  logic ref_busy, act_ready;
  logic [SA_W-1:0] ref_sa;
  int checks = 0, errors = 0, nref = 0;

  always #5 clk = ~clk;

  subarray_refresh_arbiter dut (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_busy(ref_busy),
    .ref_sa(ref_sa), .act_valid(act_valid), .act_row(act_row), .act_ready(act_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 200 && ref_busy; g++) tick();
  endtask

  task automatic start_ref();
    ref_req = 1; tick(); ref_req = 0; nref++;
  endtask

  function automatic int exp_sa(input int k);
    return ((k * REF_ROWS) >> (ROW_W - SA_W)) % (1 << SA_W);
  endfunction

  // cycle-by-cycle ready prediction; first ext_cyc cycles are under refresh
  task automatic spacing_run(input int ncyc, input int ext_cyc, input string tag);
    int gh[4];
    int gn = 0;
    int rl, fl;
    bit e;
    act_valid = 1;
    act_row = 10'h100;
    for (int t = 0; t < ncyc; t++) begin
      #1;
      rl = (t < ext_cyc) ? TRRD_EXT : TRRD;
      fl = (t < ext_cyc) ? TFAW_EXT : TFAW;
      e = (gn == 0 || t - gh[0] >= rl) && (gn < 4 || t - gh[3] >= fl);
      chk(act_ready == e, tag, act_ready, e);
      if (e) begin
        gh[3] = gh[2]; gh[2] = gh[1]; gh[1] = gh[0]; gh[0] = t;
        if (gn < 4) gn++;
      end
      tick();
    end
    act_valid = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bl;
    repeat (3) tick();
    rst_n = 1;
    #1;
    chk(ref_busy == 0, "R1 busy", ref_busy, 0);
    chk(ref_sa == 0, "R1 sa", ref_sa, 0);
    chk(act_ready == 1, "R1 ready", act_ready, 1);
    tick();

    // start cycle blocks only the subarray starting refresh
    ref_req = 1; act_row = 10'h000; #1;
    chk(act_ready == 0, "R5 start-cycle block", act_ready, 0);
    act_row = 10'h180; #1;
    chk(act_ready == 1, "R6 start-cycle other", act_ready, 1);
    tick(); ref_req = 0; nref++;
    chk(ref_busy == 1, "R2 busy rise", ref_busy, 1);
    chk(ref_sa == 0, "R2 sa", ref_sa, 0);
    for (int i = 0; i < 8; i++) begin
      act_row = VEC[i][10:1]; #1;
      chk(act_ready == VEC[i][0], VEC[i][0] ? "R6 other subarray" : "R5 same subarray",
          act_ready, VEC[i][0]);
      tick();
    end
    bl = 8;
    for (int g = 0; g < 100 && ref_busy; g++) begin bl++; tick(); end
    chk(bl == TRFC, "R2 busy length", bl, TRFC);

    // ignored refresh request mid-refresh
    tick();
    start_ref();
    bl = 0;
    for (int g = 0; g < 100 && ref_busy; g++) begin
      bl++;
      ref_req = (bl == 5);
      tick();
    end
    ref_req = 0;
    chk(bl == TRFC, "R3 busy not extended", bl, TRFC);

    // pointer walk and wrap
    for (int k = nref; k <= 128; k++) begin
      tick();
      start_ref();
      chk(ref_sa == exp_sa(k), "R4 sa sequence", ref_sa, exp_sa(k));
      wait_idle();
    end
    chk(ref_sa == 0, "R4 wrap", ref_sa, 0);

    // normal spacing
    repeat (20) tick();
    spacing_run(26, 0, "R7 R8 normal spacing");

    // extended spacing during refresh
    repeat (20) tick();
    start_ref();
    spacing_run(34, TRFC, "R6 R7 R8 extended spacing");

    // stall on refreshing subarray
    repeat (20) tick();
    start_ref();
    act_valid = 1; act_row = 10'h040;
    bl = 0;
    for (int g = 0; g < 100; g++) begin
      #1;
      if (act_ready) break;
      bl++;
      tick();
    end
    chk(bl == TRFC, "R9 stall until refresh ends", bl, TRFC);
    tick();
    #1;
    chk(act_ready == 0, "R9 ready low after transfer", act_ready, 0);
    act_valid = 0;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule